// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store unit and a memory port one word wide. Every access it takes in (an address, a size of one, two or four bytes, and a read or write direction) is tested for natural alignment. An access is naturally aligned when its address is a multiple of its size. Aligned accesses become one word-wide memory beat. They take the same number of cycles whichever policy is selected.

A policy input decides what happens to a misaligned access. In strict mode the access is dropped before it reaches memory, and a one-cycle trap pulse reports the faulting address. In permissive mode the access is serviced. If it stays inside one word, it is issued as a single beat with the matching byte enables. If it runs past a word boundary, it is issued as two aligned beats, the lower word first. On reads the two returned words are shifted and merged into one right-justified result. On writes the data bytes are steered onto the lanes of each beat, and a single completion is returned after the second beat.

The block handles one access at a time. Memory beats must be answered in order, at least one cycle after they are accepted.

Top module: `misalign_splitter`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_ready` is high and `mem_valid`, `rsp_valid` and `trap_valid` are low.
- R2: Size codes are 0 for a byte, 1 for a halfword and 2 for a word. A byte access is never misaligned. A halfword access is misaligned when address bit 0 is set. A word access is misaligned when either of address bits 1:0 is set.
- R3: With `cfg_split` low, a misaligned access is accepted, and on the next cycle `trap_valid` is high for exactly one cycle with `trap_addr` equal to the access address. That access issues no memory beat, gives no response, changes no memory byte, and leaves `req_ready` high.
- R4: Under either policy, an aligned access issues exactly one beat to the address with its low two bits cleared. `rsp_valid` rises two cycles after acceptance when memory accepts at once.
- R5: With `cfg_split` high, a misaligned access that ends inside its word issues one beat whose `mem_be` has bit i set exactly for lanes offset through offset+size-1.
- R6: With `cfg_split` high, an access that crosses a word boundary issues two beats: first the lower word, with lanes offset..3 enabled, then the next word, with lanes 0..offset+size-5 enabled. `rsp_valid` rises three cycles after acceptance when memory accepts every beat at once.
- R7: Read data on `rsp_rdata` is little-endian and right-justified. The byte at the access address sits in bits 7:0, and the bits above the access size are zero.
- R8: Write data byte k (bits 8k+7:8k) is stored at address+k. Exactly one `rsp_valid` pulse, with `rsp_rdata` zero, is returned per write, after its last beat.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values.
- R10: `req_ready` stays low from the acceptance of a serviced access until its response cycle, so no beat is issued while a new access could be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 1 | 1: split or mask misaligned accesses; 0: trap on them |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | SZ_W | Size code: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Merged read data, zero for writes |
| trap_valid | output | 1 | One-cycle misalignment trap pulse |
| trap_addr | output | ADDR_W | Faulting address |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_be | output | BYTES | Byte-lane enables of the beat |
| mem_wdata | output | DATA_W | Lane-steered write data |
| mem_rvalid | input | 1 | In-order beat response |
| mem_rdata | input | DATA_W | Word returned for a beat |

## Verification
Each of the three sizes is tried at aligned offsets and at every misaligned offset that matters, under both policies. This separates the trap decision from the split decision: a halfword at offset 1 must be masked, while one at offset 3 must be split. Writes that straddle a boundary are followed by reads whose windows overlap them, which shows whether lane steering and read merging agree byte by byte. A read after a trapped write shows the trap left memory untouched. A split read with memory held off for several cycles shows that a stalled beat is held steady and that merging does not depend on response timing.

// File: rtl/mas_pkg.sv
package mas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/mas_decode.sv
// Alignment test, lane mask and data steering for one access.
module mas_decode #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  input  logic [DATA_W-1:0] wdata,
  output logic              misaligned,
  output logic              crosses,
  output logic [BYTES-1:0]  be_lo,
  output logic [BYTES-1:0]  be_hi,
  output logic [DATA_W-1:0] wd_lo,
  output logic [DATA_W-1:0] wd_hi,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [ADDR_W-1:0] addr_hi
);

  logic [OFF_W-1:0]    off;
  logic [SZ_W-1:0]     sz_eff;
  logic [OFF_W:0]      nbytes;
  logic [OFF_W-1:0]    align_mask;
  logic [2*BYTES-1:0]  lane_base;
  logic [2*BYTES-1:0]  lane_wide;
  logic [2*DATA_W-1:0] data_wide;

  always_comb begin
    off = addr[OFF_W-1:0];
    if (size > SZ_W'(OFF_W)) sz_eff = SZ_W'(OFF_W);
    else                     sz_eff = size;
    nbytes     = (OFF_W+1)'(1) << sz_eff;
    align_mask = OFF_W'(nbytes - (OFF_W+1)'(1));
    lane_base  = ((2*BYTES)'(1) << nbytes) - (2*BYTES)'(1);
    lane_wide  = lane_base << off;
    data_wide  = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
  end

  assign misaligned = |(off & align_mask);
  assign crosses    = |lane_wide[2*BYTES-1:BYTES];
  assign be_lo      = lane_wide[BYTES-1:0];
  assign be_hi      = lane_wide[2*BYTES-1:BYTES];
  assign wd_lo      = data_wide[DATA_W-1:0];
  assign wd_hi      = data_wide[2*DATA_W-1:DATA_W];
  assign addr_lo    = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign addr_hi    = addr_lo + ADDR_W'(BYTES);

endmodule

// File: rtl/mas_merge.sv
// Joins the two returned words, aligns the addressed bytes to lane 0
// and clears the lanes above the access size.
module mas_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [SZ_W-1:0]   size,
  output logic [DATA_W-1:0] data
);

  logic [2*DATA_W-1:0] joined;
  logic [SZ_W-1:0]     sz_eff;
  logic [OFF_W:0]      nbytes;

  always_comb begin
    joined = {hi_word, lo_word} >> {off, 3'b000};
    if (size > SZ_W'(OFF_W)) sz_eff = SZ_W'(OFF_W);
    else                     sz_eff = size;
    nbytes = (OFF_W+1)'(1) << sz_eff;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign data[8*g +: 8] = ((OFF_W+1)'(g) < nbytes) ? joined[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_split,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              trap_valid,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);

  import mas_pkg::*;

  seq_state_e state_q;

  // decoded view of the incoming request
  logic              dec_mis;
  logic              dec_cross;
  logic [BYTES-1:0]  dec_be_lo;
  logic [BYTES-1:0]  dec_be_hi;
  logic [DATA_W-1:0] dec_wd_lo;
  logic [DATA_W-1:0] dec_wd_hi;
  logic [ADDR_W-1:0] dec_addr_lo;
  logic [ADDR_W-1:0] dec_addr_hi;

  // beat currently offered to memory
  logic              mem_valid_q;
  logic              mem_we_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [BYTES-1:0]  mem_be_q;
  logic [DATA_W-1:0] mem_wdata_q;

  // parked upper beat of a split access
  logic [ADDR_W-1:0] hi_addr_q;
  logic [BYTES-1:0]  hi_be_q;
  logic [DATA_W-1:0] hi_wd_q;

  // access bookkeeping for the merge
  logic              split_q;
  logic              second_q;
  logic              rcv_q;
  logic [OFF_W-1:0]  off_q;
  logic [SZ_W-1:0]   size_q;
  logic [DATA_W-1:0] lo_word_q;

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              trap_valid_q;
  logic [ADDR_W-1:0] trap_addr_q;

  logic              accept;
  logic              do_trap;
  logic              start;
  logic              mem_fire;
  logic              last_rsp;
  logic [DATA_W-1:0] merge_lo;
  logic [DATA_W-1:0] merged;

  mas_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .addr       (req_addr),
    .size       (req_size),
    .wdata      (req_wdata),
    .misaligned (dec_mis),
    .crosses    (dec_cross),
    .be_lo      (dec_be_lo),
    .be_hi      (dec_be_hi),
    .wd_lo      (dec_wd_lo),
    .wd_hi      (dec_wd_hi),
    .addr_lo    (dec_addr_lo),
    .addr_hi    (dec_addr_hi)
  );

  assign merge_lo = split_q ? lo_word_q : mem_rdata;

  mas_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_word (merge_lo),
    .hi_word (mem_rdata),
    .off     (off_q),
    .size    (size_q),
    .data    (merged)
  );

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign do_trap  = accept && dec_mis && !cfg_split;
  assign start    = accept && !do_trap;
  assign mem_fire = mem_valid_q && mem_ready;
  assign last_rsp = mem_rvalid && (!split_q || rcv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mem_valid_q  <= 1'b0;
      mem_we_q     <= 1'b0;
      mem_addr_q   <= '0;
      mem_be_q     <= '0;
      mem_wdata_q  <= '0;
      hi_addr_q    <= '0;
      hi_be_q      <= '0;
      hi_wd_q      <= '0;
      split_q      <= 1'b0;
      second_q     <= 1'b0;
      rcv_q        <= 1'b0;
      off_q        <= '0;
      size_q       <= '0;
      lo_word_q    <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
      trap_valid_q <= 1'b0;
      trap_addr_q  <= '0;
    end else begin
      trap_valid_q <= do_trap;
      if (do_trap) trap_addr_q <= req_addr;
      rsp_valid_q <= 1'b0;

      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mem_valid_q <= 1'b1;
            mem_we_q    <= req_write;
            mem_addr_q  <= dec_addr_lo;
            mem_be_q    <= dec_be_lo;
            mem_wdata_q <= dec_wd_lo;
            hi_addr_q   <= dec_addr_hi;
            hi_be_q     <= dec_be_hi;
            hi_wd_q     <= dec_wd_hi;
            split_q     <= dec_cross;
            second_q    <= 1'b0;
            rcv_q       <= 1'b0;
            off_q       <= req_addr[OFF_W-1:0];
            size_q      <= req_size;
            state_q     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_fire) begin
            if (split_q && !second_q) begin
              mem_addr_q  <= hi_addr_q;
              mem_be_q    <= hi_be_q;
              mem_wdata_q <= hi_wd_q;
              second_q    <= 1'b1;
            end else begin
              mem_valid_q <= 1'b0;
              state_q     <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase

      if (mem_rvalid && (state_q != ST_IDLE)) begin
        if (last_rsp) begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= mem_we_q ? '0 : merged;
          state_q     <= ST_IDLE;
        end else begin
          lo_word_q <= mem_rdata;
          rcv_q     <= 1'b1;
        end
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign trap_valid = trap_valid_q;
  assign trap_addr  = trap_addr_q;
  assign mem_valid  = mem_valid_q;
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_be     = mem_be_q;
  assign mem_wdata  = mem_wdata_q;

endmodule

// File: rtl/misalign_splitter_chk.sv
module misalign_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              trap_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BYTES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata
);

  // R1: reset leaves the outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_valid && !rsp_valid && !trap_valid));

  // R3: a trap never coincides with a memory beat or a response
  p_trap_no_beat_r3: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (!mem_valid && !rsp_valid));

  // R4: every beat targets a word boundary
  p_word_addr_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R6: every beat enables at least one lane
  p_lanes_used_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be != '0));

  // R9: a stalled beat holds steady
  p_beat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_be) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: no new request is taken while a beat is outstanding
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

endmodule

bind misalign_splitter misalign_splitter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .trap_valid (trap_valid),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata)
);

// File: tb/misalign_splitter_tb_top.sv
`timescale 1ns/1ps
module misalign_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_split = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        trap_valid;
  logic [31:0] trap_addr;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #4 clk = ~clk;

  misalign_splitter dut_i (
    .clk(clk), .rst(rst), .cfg_split(cfg_split),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .trap_valid(trap_valid), .trap_addr(trap_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 29 + 5) & 255);
  endfunction

  // memory model: 16 words, in-order response one cycle after acceptance
  logic [31:0] mem_arr [16];
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= 32'd0;
      for (int w = 0; w < 16; w++)
        mem_arr[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    end else begin
      mem_rvalid <= mem_valid && mem_ready;
      if (mem_valid && mem_ready) begin
        mem_rdata <= mem_arr[mem_addr[5:2]];
        if (mem_we)
          for (int j = 0; j < 4; j++)
            if (mem_be[j]) mem_arr[mem_addr[5:2]][8*j +: 8] <= mem_wdata[8*j +: 8];
      end
    end
  end

  // beat and response monitors
  int          nb_tot = 0;
  int          rsp_tot = 0;
  logic [31:0] b_addr [4];
  logic [3:0]  b_be   [4];
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      b_addr[nb_tot % 4] <= mem_addr;
      b_be[nb_tot % 4]   <= mem_be;
      nb_tot <= nb_tot + 1;
    end
    if (rsp_valid) rsp_tot <= rsp_tot + 1;
  end

  logic [7:0] shadow [64];
  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a, input int sz);
    logic [31:0] r = 32'd0;
    for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = shadow[a + i];
    return r;
  endfunction

  typedef struct packed {
    logic        pol;
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [1:0]  beats;
    logic        trap;
    logic [1:0]  cyc;
  } acc_vec_t;

  localparam int NV = 22;
  localparam acc_vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd0, 8'h05, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b0, 1'b0, 2'd1, 8'h06, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b0, 1'b0, 2'd1, 8'h07, 32'h0,        2'd0, 1'b1, 2'd0},
    '{1'b0, 1'b0, 2'd2, 8'h08, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b0, 1'b0, 2'd2, 8'h0A, 32'h0,        2'd0, 1'b1, 2'd0},
    '{1'b0, 1'b1, 2'd2, 8'h11, 32'h12345678, 2'd0, 1'b1, 2'd0},
    '{1'b1, 1'b0, 2'd1, 8'h05, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h0D, 32'h0,        2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b0, 2'd1, 8'h0B, 32'h0,        2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b0, 2'd2, 8'h0F, 32'h0,        2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b1, 2'd2, 8'h21, 32'hDEADBEEF, 2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b1, 2'd1, 8'h27, 32'h0000A55A, 2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b1, 2'd0, 8'h2B, 32'h00000077, 2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h20, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h24, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h29, 32'h0,        2'd2, 1'b0, 2'd3},
    '{1'b1, 1'b1, 2'd2, 8'h30, 32'hCAFEF00D, 2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd1, 8'h31, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b0, 1'b0, 2'd0, 8'h33, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h10, 32'h0,        2'd1, 1'b0, 2'd2},
    '{1'b1, 1'b0, 2'd2, 8'h06, 32'h0,        2'd2, 1'b0, 2'd3},
    '{1'b0, 1'b0, 2'd2, 8'h1C, 32'h0,        2'd1, 1'b0, 2'd2}
  };

  task automatic run_vec(input acc_vec_t v);
    int s_nb, s_rsp, cyc, off, n;
    logic [7:0]  lanes;
    logic [31:0] exp_d;
    off   = int'(v.addr[1:0]);
    n     = 1 << v.sz;
    lanes = 8'(((1 << n) - 1) << off);
    exp_d = v.we ? 32'd0 : exp_read(int'(v.addr), int'(v.sz));
    @(negedge clk);
    cfg_split = v.pol; req_write = v.we; req_size = v.sz;
    req_addr = {24'd0, v.addr}; req_wdata = v.wd; req_valid = 1'b1;
    s_nb = nb_tot; s_rsp = rsp_tot;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    // R2: trap decision under strict policy follows the alignment rule
    chk(trap_valid == v.trap, "R2 trap decision", {31'd0, trap_valid}, {31'd0, v.trap});
    if (v.trap) begin
      chk(trap_addr == {24'd0, v.addr}, "R3 trap_addr", trap_addr, {24'd0, v.addr});
      chk(req_ready == 1'b1, "R3 stays idle", {31'd0, req_ready}, 32'd1);
      @(posedge clk); @(negedge clk);
      chk(trap_valid == 1'b0, "R3 one-cycle trap", {31'd0, trap_valid}, 32'd0);
      repeat (3) @(negedge clk);
      chk(nb_tot == s_nb, "R3 no memory beat", 32'(nb_tot - s_nb), 32'd0);
      chk(rsp_tot == s_rsp, "R3 no response", 32'(rsp_tot - s_rsp), 32'd0);
    end else begin
      chk(req_ready == 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
      while (!rsp_valid && cyc < 8) begin
        @(posedge clk); @(negedge clk);
        cyc++;
      end
      if (v.beats == 2'd2)
        chk(cyc == int'(v.cyc), "R6 split latency", 32'(cyc), {30'd0, v.cyc});
      else
        chk(cyc == int'(v.cyc), "R4 single-beat latency", 32'(cyc), {30'd0, v.cyc});
      if (v.we)
        chk(rsp_rdata == 32'd0, "R8 write response data", rsp_rdata, 32'd0);
      else
        chk(rsp_rdata == exp_d, "R7 read data", rsp_rdata, exp_d);
      chk(32'(nb_tot - s_nb) == {30'd0, v.beats}, "R6 beat count",
          32'(nb_tot - s_nb), {30'd0, v.beats});
      chk(b_addr[s_nb % 4] == {24'd0, v.addr[7:2], 2'b00}, "R4 first beat address",
          b_addr[s_nb % 4], {24'd0, v.addr[7:2], 2'b00});
      chk(b_be[s_nb % 4] == lanes[3:0], "R5 first beat lanes",
          {28'd0, b_be[s_nb % 4]}, {28'd0, lanes[3:0]});
      if (v.beats == 2'd2) begin
        chk(b_addr[(s_nb + 1) % 4] == {24'd0, v.addr[7:2], 2'b00} + 32'd4,
            "R6 second beat address", b_addr[(s_nb + 1) % 4],
            {24'd0, v.addr[7:2], 2'b00} + 32'd4);
        chk(b_be[(s_nb + 1) % 4] == lanes[7:4], "R6 second beat lanes",
            {28'd0, b_be[(s_nb + 1) % 4]}, {28'd0, lanes[7:4]});
      end
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == 1'b0, "R8 single response pulse", {31'd0, rsp_valid}, 32'd0);
      if (v.we)
        for (int i = 0; i < n; i++) shadow[int'(v.addr) + i] = v.wd[8*i +: 8];
    end
  endtask

  initial begin
    for (int b = 0; b < 64; b++) shadow[b] = pat(b);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && rsp_valid == 1'b0 && trap_valid == 1'b0,
        "R1 reset outputs", {28'd0, req_ready, mem_valid, rsp_valid, trap_valid}, 32'h8);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_valid == 1'b0, "R1 after reset",
        {30'd0, req_ready, mem_valid}, 32'h2);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R9: split read with memory stalled; beat must stay on the lower word
    begin
      logic [31:0] exp_d;
      exp_d = exp_read(14, 2);
      @(negedge clk);
      mem_ready = 1'b0; cfg_split = 1'b1; req_write = 1'b0; req_size = 2'd2;
      req_addr = 32'h0E; req_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_valid == 1'b1 && mem_addr == 32'h0C && mem_be == 4'b1100,
          "R9 stalled beat held", mem_addr, 32'h0C);
      mem_ready = 1'b1;
      for (int c = 0; c < 10 && !rsp_valid; c++) @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_rdata == exp_d, "R7 data after stall", rsp_rdata, exp_d);
      @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule